// File: doc/BRIEF.md
# Fine-Grained Write Trap Checker

This block decides whether a write to a debug, trace, statistical-profiling or performance-monitor control register has to be diverted to the hypervisor level. It also chooses the exception class that the hypervisor is told about. A 64-bit trap-control word arrives as an input. Each of its bit positions governs one group of target registers. Each request names that group by its bit index, and also gives the current privilege level, the instruction form and a flag for an already-pending higher-priority exception. Hypervisor and monitor configuration, the host-mode pair, the execution state of level 1 and a feature-present mask are also inputs.

The decision is registered. The trap flag and the exception class appear one clock after a valid request. The exception entry itself, the syndrome assembly and the target registers are handled elsewhere.

Top module: `fgwt_trap_checker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, trap_o is 0 and ec_o is 0.
- R2: No trap is raised unless hyp_en_i is 1 and either mon_present_i is 0 or mon_fgt_en_i is 1.
- R3: Control bits 62, 61 and 60 have negative polarity. A 0 in one of these bits enables its trap and a 1 disables it.
- R4: Every other implemented, non-reserved control bit enables its trap when it is 1. A trapped 64-bit move (form 0) from level 1 reports exception class 0x18.
- R5: Reserved bits never cause a trap, whatever value they hold. The reserved bits are 63, 59, 58, 51, 47, 43, 40, 39, 38, 34, 30, 22, 9 and 6.
- R6: A bit whose feat_i entry is 0 never causes a trap.
- R7: A request with req_hiprio_i set never produces a trap.
- R8: The performance-monitor bits are 21, 20, 19, 18, 16, 15, 14, 13 and 12. For these bits, a 64-bit move from level 0 or from level 1 traps with class 0x18. A 32-bit coprocessor move (form 1) from level 0 traps with class 0x03. A double-word move (form 2) from level 0 traps with class 0x04, and only for bit 15. The forms not listed here never trap for these bits.
- R9: The performance-monitor bits trap only when {e2h_i, tge_i} is not {1,1} and el1_a64_i is 1. Other bits do not depend on these inputs.
- R10: Bit 17 and all other bits outside the performance-monitor set trap only 64-bit moves from level 1. Levels 2 and 3 (req_level_i values 2 and 3) never trap.
- R11: Trap and class appear exactly one cycle after the request. A cycle with req_valid_i at 0 gives trap_o 0 in the next cycle, and ec_o is 0 whenever trap_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_word_i | input | 64 | Trap-control word |
| feat_i | input | 64 | Feature-present mask, one bit per control bit |
| hyp_en_i | input | 1 | Hypervisor level implemented and enabled in the current security state |
| mon_present_i | input | 1 | Monitor level exists |
| mon_fgt_en_i | input | 1 | Monitor's fine-grained-trap enable |
| e2h_i | input | 1 | Host-mode bit of the hypervisor configuration |
| tge_i | input | 1 | Trap-general bit of the hypervisor configuration |
| el1_a64_i | input | 1 | Level 1 runs in 64-bit state |
| req_valid_i | input | 1 | Request strobe |
| req_group_i | input | 6 | Register-group index (control bit position) |
| req_level_i | input | 2 | Current privilege level, 0 to 3 |
| req_form_i | input | 2 | 0 is a 64-bit move, 1 is a 32-bit coprocessor move, 2 is a double-word move, 3 is unused |
| req_hiprio_i | input | 1 | The write already raises a higher-priority exception |
| trap_o | output | 1 | Write must be trapped |
| ec_o | output | 6 | Exception class of the trap, 0 when there is no trap |

## Verification
The assertions assume that the configuration inputs and the control word are stable around each request. They also assume that req_group_i and the other request fields are only meaningful while req_valid_i is high. The bench changes every input only on the falling clock edge, and it holds the configuration fixed across the sampling edge of each request. It returns to a known default configuration after each directed case, so that every table vector is judged against the same gating state.

// File: rtl/fgwt_pkg.sv
package fgwt_pkg;

  localparam int unsigned CTL_W = 64;
  localparam int unsigned GRP_W = $clog2(CTL_W);
  localparam int unsigned EC_W  = 6;

  typedef enum logic [1:0] {
    FORM_MOVE64 = 2'd0,
    FORM_COP32  = 2'd1,
    FORM_COPDW  = 2'd2,
    FORM_NONE   = 2'd3
  } form_e;

  localparam logic [EC_W-1:0] EC_MOVE64 = 6'h18;
  localparam logic [EC_W-1:0] EC_COP32  = 6'h03;
  localparam logic [EC_W-1:0] EC_COPDW  = 6'h04;
  localparam logic [EC_W-1:0] EC_NONE   = 6'h00;

  function automatic logic [CTL_W-1:0] mk_rsvd_mask();
    logic [CTL_W-1:0] m;
    m = '0;
    m[63] = 1'b1; m[59] = 1'b1; m[58] = 1'b1; m[51] = 1'b1;
    m[47] = 1'b1; m[43] = 1'b1; m[40] = 1'b1; m[39] = 1'b1;
    m[38] = 1'b1; m[34] = 1'b1; m[30] = 1'b1; m[22] = 1'b1;
    m[9]  = 1'b1; m[6]  = 1'b1;
    return m;
  endfunction

  function automatic logic [CTL_W-1:0] mk_neg_mask();
    logic [CTL_W-1:0] m;
    m = '0;
    m[62] = 1'b1; m[61] = 1'b1; m[60] = 1'b1;
    return m;
  endfunction

  function automatic logic [CTL_W-1:0] mk_wide_mask();
    logic [CTL_W-1:0] m;
    m = '0;
    m[21] = 1'b1; m[20] = 1'b1; m[19] = 1'b1; m[18] = 1'b1;
    m[16] = 1'b1; m[15] = 1'b1; m[14] = 1'b1; m[13] = 1'b1;
    m[12] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/fgwt_enable_map.sv
module fgwt_enable_map
  import fgwt_pkg::*;
#(
  parameter logic [CTL_W-1:0] RSVD_MASK = mk_rsvd_mask(),
  parameter logic [CTL_W-1:0] NEG_MASK  = mk_neg_mask()
) (
  input  logic [CTL_W-1:0] ctl_i,
  input  logic [CTL_W-1:0] feat_i,
  output logic [CTL_W-1:0] en_o
);

  for (genvar i = 0; i < CTL_W; i++) begin : g_bit
    if (RSVD_MASK[i]) begin : g_rsvd
      assign en_o[i] = 1'b0 & ctl_i[i] & feat_i[i];
    end else if (NEG_MASK[i]) begin : g_neg
      assign en_o[i] = feat_i[i] & ~ctl_i[i];
    end else begin : g_pos
      assign en_o[i] = feat_i[i] & ctl_i[i];
    end
  end

endmodule

// File: rtl/fgwt_gate.sv
module fgwt_gate (
  input  logic hyp_en_i,
  input  logic mon_present_i,
  input  logic mon_fgt_en_i,
  input  logic hiprio_i,
  output logic open_o
);

  logic mon_ok;

  always_comb begin
    mon_ok = ~mon_present_i | mon_fgt_en_i;
    open_o = hyp_en_i & mon_ok & ~hiprio_i;
  end

endmodule

// File: rtl/fgwt_route.sv
module fgwt_route
  import fgwt_pkg::*;
#(
  parameter logic [CTL_W-1:0] WIDE_MASK = mk_wide_mask(),
  parameter int unsigned      DW_BIT    = 15
) (
  input  logic [GRP_W-1:0] group_i,
  input  logic [1:0]       level_i,
  input  logic [1:0]       form_i,
  input  logic             e2h_i,
  input  logic             tge_i,
  input  logic             el1_a64_i,
  output logic             allow_o,
  output logic [EC_W-1:0]  ec_o
);

  localparam logic [GRP_W-1:0] DW_IDX = GRP_W'(DW_BIT);

  logic  wide;
  logic  qual;
  form_e form;

  always_comb begin
    wide    = WIDE_MASK[group_i];
    qual    = ~(e2h_i & tge_i) & el1_a64_i;
    form    = form_e'(form_i);
    allow_o = 1'b0;
    ec_o    = EC_NONE;
    if (!wide) begin
      if (level_i == 2'd1 && form == FORM_MOVE64) begin
        allow_o = 1'b1;
        ec_o    = EC_MOVE64;
      end
    end else if (qual) begin
      unique case (level_i)
        2'd1: begin
          if (form == FORM_MOVE64) begin
            allow_o = 1'b1;
            ec_o    = EC_MOVE64;
          end
        end
        2'd0: begin
          unique case (form)
            FORM_MOVE64: begin allow_o = 1'b1; ec_o = EC_MOVE64; end
            FORM_COP32:  begin allow_o = 1'b1; ec_o = EC_COP32;  end
            FORM_COPDW: begin
              if (group_i == DW_IDX) begin
                allow_o = 1'b1;
                ec_o    = EC_COPDW;
              end
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  // R10: any allowed write comes from level 0 or level 1
  always_comb begin
    p_level_r10: assert (!allow_o || level_i <= 2'd1);
  end

  // R8: forms other than the 64-bit move are allowed only for level-0 writes to wide bits
  always_comb begin
    p_cop_form_r8: assert (!(allow_o && form_i != 2'd0) || (level_i == 2'd0 && wide));
  end

endmodule

// File: rtl/fgwt_trap_checker.sv
module fgwt_trap_checker
  import fgwt_pkg::*;
#(
  parameter logic [CTL_W-1:0] RSVD_MASK = mk_rsvd_mask(),
  parameter logic [CTL_W-1:0] NEG_MASK  = mk_neg_mask(),
  parameter logic [CTL_W-1:0] WIDE_MASK = mk_wide_mask(),
  parameter int unsigned      DW_BIT    = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTL_W-1:0] ctl_word_i,
  input  logic [CTL_W-1:0] feat_i,
  input  logic             hyp_en_i,
  input  logic             mon_present_i,
  input  logic             mon_fgt_en_i,
  input  logic             e2h_i,
  input  logic             tge_i,
  input  logic             el1_a64_i,
  input  logic             req_valid_i,
  input  logic [GRP_W-1:0] req_group_i,
  input  logic [1:0]       req_level_i,
  input  logic [1:0]       req_form_i,
  input  logic             req_hiprio_i,
  output logic             trap_o,
  output logic [EC_W-1:0]  ec_o
);

  logic [CTL_W-1:0] bit_en;
  logic             gate_open;
  logic             route_ok;
  logic [EC_W-1:0]  route_ec;
  logic             trap_d, trap_q;
  logic [EC_W-1:0]  ec_d, ec_q;
  logic             upd_en;

  fgwt_enable_map #(
    .RSVD_MASK (RSVD_MASK),
    .NEG_MASK  (NEG_MASK)
  ) u_map (
    .ctl_i  (ctl_word_i),
    .feat_i (feat_i),
    .en_o   (bit_en)
  );

  fgwt_gate u_gate (
    .hyp_en_i      (hyp_en_i),
    .mon_present_i (mon_present_i),
    .mon_fgt_en_i  (mon_fgt_en_i),
    .hiprio_i      (req_hiprio_i),
    .open_o        (gate_open)
  );

  fgwt_route #(
    .WIDE_MASK (WIDE_MASK),
    .DW_BIT    (DW_BIT)
  ) u_route (
    .group_i   (req_group_i),
    .level_i   (req_level_i),
    .form_i    (req_form_i),
    .e2h_i     (e2h_i),
    .tge_i     (tge_i),
    .el1_a64_i (el1_a64_i),
    .allow_o   (route_ok),
    .ec_o      (route_ec)
  );

  always_comb begin
    trap_d = req_valid_i & gate_open & bit_en[req_group_i] & route_ok;
    ec_d   = trap_d ? route_ec : EC_NONE;
    upd_en = req_valid_i | trap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_q <= 1'b0;
      ec_q   <= EC_NONE;
    end else if (upd_en) begin
      trap_q <= trap_d;
      ec_q   <= ec_d;
    end
  end

  assign trap_o = trap_q;
  assign ec_o   = ec_q;

  p_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !(hyp_en_i && (!mon_present_i || mon_fgt_en_i))) |=> !trap_o);

  p_rsvd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && RSVD_MASK[req_group_i]) |=> !trap_o);

  p_feat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !feat_i[req_group_i]) |=> !trap_o);

  p_hiprio_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_hiprio_i |=> !trap_o);

  p_dw_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && ec_o == EC_COPDW) |-> ($past(req_group_i) == GRP_W'(DW_BIT)));

  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !trap_o);

  p_ec_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> (ec_o == EC_NONE));

  p_ec_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (ec_o == EC_MOVE64 || ec_o == EC_COP32 || ec_o == EC_COPDW));

endmodule

// File: tb/fgwt_trap_checker_tb_top.sv
module fgwt_trap_checker_tb_top;

  typedef struct packed {
    logic [5:0] grp;
    logic [1:0] lvl;
    logic [1:0] form;
    logic       v;
    logic       et;
    logic [5:0] eec;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{6'd5,  2'd1, 2'd0, 1'b1, 1'b1, 6'h18},  // R4 positive bit set
    '{6'd5,  2'd1, 2'd0, 1'b0, 1'b0, 6'h00},  // R4 positive bit clear
    '{6'd62, 2'd1, 2'd0, 1'b0, 1'b1, 6'h18},  // R3 negative bit at 0 traps
    '{6'd62, 2'd1, 2'd0, 1'b1, 1'b0, 6'h00},  // R3 negative bit at 1 is quiet
    '{6'd60, 2'd1, 2'd0, 1'b0, 1'b1, 6'h18},  // R3
    '{6'd61, 2'd1, 2'd0, 1'b1, 1'b0, 6'h00},  // R3
    '{6'd63, 2'd1, 2'd0, 1'b1, 1'b0, 6'h00},  // R5 reserved
    '{6'd22, 2'd1, 2'd0, 1'b1, 1'b0, 6'h00},  // R5 reserved
    '{6'd21, 2'd0, 2'd0, 1'b1, 1'b1, 6'h18},  // R8 level-0 64-bit move
    '{6'd21, 2'd0, 2'd1, 1'b1, 1'b1, 6'h03},  // R8 level-0 32-bit move
    '{6'd15, 2'd0, 2'd2, 1'b1, 1'b1, 6'h04},  // R8 double-word on bit 15
    '{6'd14, 2'd0, 2'd2, 1'b1, 1'b0, 6'h00},  // R8 double-word on other bit
    '{6'd21, 2'd1, 2'd1, 1'b1, 1'b0, 6'h00},  // R8 32-bit move from level 1
    '{6'd17, 2'd0, 2'd0, 1'b1, 1'b0, 6'h00},  // R10 bit 17 at level 0
    '{6'd17, 2'd1, 2'd0, 1'b1, 1'b1, 6'h18},  // R10 bit 17 at level 1
    '{6'd5,  2'd1, 2'd1, 1'b1, 1'b0, 6'h00},  // R10 32-bit move, plain bit
    '{6'd12, 2'd2, 2'd0, 1'b1, 1'b0, 6'h00},  // R10 level 2
    '{6'd33, 2'd0, 2'd0, 1'b1, 1'b0, 6'h00}   // R10 plain bit at level 0
  };

  logic        clk;
  logic        rst_n;
  logic [63:0] ctl;
  logic [63:0] feat;
  logic        hyp_en, mon_pr, mon_fgt, e2h, tge, a64;
  logic        valid;
  logic [5:0]  grp;
  logic [1:0]  lvl;
  logic [1:0]  form;
  logic        hiprio;
  logic        trap;
  logic [5:0]  ec;

  int checks;
  int errors;
  bit done;

  fgwt_trap_checker dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .ctl_word_i    (ctl),
    .feat_i        (feat),
    .hyp_en_i      (hyp_en),
    .mon_present_i (mon_pr),
    .mon_fgt_en_i  (mon_fgt),
    .e2h_i         (e2h),
    .tge_i         (tge),
    .el1_a64_i     (a64),
    .req_valid_i   (valid),
    .req_group_i   (grp),
    .req_level_i   (lvl),
    .req_form_i    (form),
    .req_hiprio_i  (hiprio),
    .trap_o        (trap),
    .ec_o          (ec)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic et, input logic [5:0] eec);
    checks++;
    if (trap !== et || ec !== eec) begin
      errors++;
      $display("FAIL %s: trap=%0b ec=0x%02h expected trap=%0b ec=0x%02h",
               req, trap, ec, et, eec);
    end
  endtask

  task automatic defaults();
    ctl = '0; feat = '1;
    hyp_en = 1'b1; mon_pr = 1'b1; mon_fgt = 1'b1;
    e2h = 1'b0; tge = 1'b0; a64 = 1'b1;
    valid = 1'b0; grp = '0; lvl = 2'd1; form = 2'd0; hiprio = 1'b0;
  endtask

  // drive at a falling edge, sample at the next falling edge (one register)
  task automatic req(input logic [5:0] g, input logic [1:0] l, input logic [1:0] f,
                     input string tag, input logic et, input logic [5:0] eec);
    valid = 1'b1; grp = g; lvl = l; form = f;
    @(negedge clk);
    chk(tag, et, eec);
    valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    defaults();
    ctl = '1;
    valid = 1'b1; grp = 6'd5;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", 1'b0, 6'h00);
    valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 1'b0, 6'h00);

    for (int i = 0; i < NV; i++) begin
      ctl = {64{VECS[i].v}};
      req(VECS[i].grp, VECS[i].lvl, VECS[i].form, $sformatf("table %0d", i),
          VECS[i].et, VECS[i].eec);
    end

    // R2 gating
    defaults(); ctl = '1;
    hyp_en = 1'b0;
    req(6'd5, 2'd1, 2'd0, "R2 hyp disabled", 1'b0, 6'h00);
    hyp_en = 1'b1; mon_fgt = 1'b0;
    req(6'd5, 2'd1, 2'd0, "R2 monitor enable off", 1'b0, 6'h00);
    mon_pr = 1'b0;
    req(6'd5, 2'd1, 2'd0, "R2 no monitor", 1'b1, 6'h18);

    // R6 feature absent
    defaults(); ctl = '1; feat[20] = 1'b0;
    req(6'd20, 2'd0, 2'd0, "R6 feature absent", 1'b0, 6'h00);
    feat = '1;
    req(6'd20, 2'd0, 2'd0, "R6 feature present", 1'b1, 6'h18);
    ctl = '0; feat[62] = 1'b0;
    req(6'd62, 2'd1, 2'd0, "R6 negative bit absent", 1'b0, 6'h00);

    // R7 higher-priority exception
    defaults(); ctl = '1; hiprio = 1'b1;
    req(6'd5, 2'd1, 2'd0, "R7 hiprio", 1'b0, 6'h00);
    hiprio = 1'b0;

    // R9 host-mode qualifier
    defaults(); ctl = '1; e2h = 1'b1; tge = 1'b1;
    req(6'd16, 2'd0, 2'd0, "R9 host mode on pmu bit", 1'b0, 6'h00);
    req(6'd17, 2'd1, 2'd0, "R9 host mode on bit 17", 1'b1, 6'h18);
    e2h = 1'b0;
    req(6'd16, 2'd0, 2'd0, "R9 tge only", 1'b1, 6'h18);
    tge = 1'b0; a64 = 1'b0;
    req(6'd13, 2'd1, 2'd0, "R9 level 1 not 64-bit", 1'b0, 6'h00);
    req(6'd5, 2'd1, 2'd0, "R9 plain bit unaffected", 1'b1, 6'h18);

    // R11 latency and idle
    defaults(); ctl = '1;
    @(negedge clk);
    valid = 1'b1; grp = 6'd5; lvl = 2'd1; form = 2'd0;
    #1;
    chk("R11 not combinational", 1'b0, 6'h00);
    @(negedge clk);
    chk("R11 one-cycle latency", 1'b1, 6'h18);
    valid = 1'b0;
    @(negedge clk);
    chk("R11 idle clears", 1'b0, 6'h00);
    grp = 6'd21; lvl = 2'd0; form = 2'd1;
    @(negedge clk);
    chk("R11 idle ignores fields", 1'b0, 6'h00);

    finish_run();
  end

endmodule